// File: doc/BRIEF.md
# Hashed Page-Table Group Address Generator

This block computes where in memory a hashed page table keeps the group of entries that may translate a given effective address. It takes a 32-bit effective address, a file of sixteen 32-bit segment registers and a 32-bit table configuration word. The top nibble of the address selects a segment. The segment's virtual segment ID is hashed with the page index to give a 19-bit hash. The upper part of the hash, masked, is merged into the table origin, and the lower part forms the group index. The result is a 64-byte-aligned group address. The block also builds the 32-bit compare word that a table walker matches against the upper word of each entry in the group.

A caller chooses the primary or secondary hash for each request. The request enters through a valid/ready handshake. Results leave one cycle later from a single registered stage, which holds its value under backpressure. All bit numbers below use the SystemVerilog convention: bit 31 is the most significant bit.

Top module: `pteg_addr_gen`

## Requirements
- R1: The segment register used is entry `effAddr[31:28]` of `segFile`. Entry i sits at `segFile[32*i+31 : 32*i]`, and its VSID is bits [23:0] of that entry.
- R2: With `hashSel` = 0, the 19-bit hash is VSID[18:0] XOR {3'b000, effAddr[27:12]}.
- R3: With `hashSel` = 1, the hash is the bitwise ones' complement of the R2 hash.
- R4: `groupAddr[31:25]` equals `tableCfg[31:25]`, which is the top seven bits of the table origin.
- R5: `groupAddr[24:16]` equals `tableCfg[24:16]` OR (`tableCfg[8:0]` AND hash[18:10]). Here `tableCfg[8:0]` is the 9-bit mask.
- R6: `groupAddr[15:6]` equals hash[9:0], and `groupAddr[5:0]` is zero.
- R7: `cmpWord` is {1'b1, VSID[23:0], hashSel, effAddr[27:22]}. That is: bit 31 valid, bits 30:7 VSID, bit 6 hash-select, bits 5:0 abbreviated page index.
- R8: A request accepted at a rising edge (`inValid` and `inReady` both high) shows its result with `outValid` high after that same edge.
- R9: While `outValid` is high and `outReady` is low, `inReady` is low, and `groupAddr` and `cmpWord` hold their values.
- R10: After reset, `outValid` is low and `inReady` is high.
- R11: Configuration bits `tableCfg[15:9]` are reserved and have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Request can be taken this cycle |
| effAddr | input | 32 | Effective address of the request |
| segFile | input | 512 | Sixteen segment registers, entry i at bits 32*i+31:32*i |
| tableCfg | input | 32 | Table origin [31:16], reserved [15:9], hash mask [8:0] |
| hashSel | input | 1 | 0 selects the primary hash, 1 the secondary |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result this cycle |
| groupAddr | output | 32 | Physical address of the entry group |
| cmpWord | output | 32 | Upper-word compare value for the group search |

## Verification
The bench sweeps every segment index with distinct VSIDs. A design that decoded the wrong address nibble would then pair addresses with the wrong VSID, and both outputs would be wrong. Mask widths run from zero to nine ones, with both hash selections. This exposes a merge that ORs the wrong hash bits into the origin, or a secondary hash that flips only part of the value. Reserved configuration bits are set at random to catch a design that leaks them into the address. Random output stalls test whether a held result changes or a new request is taken while the output stage is full.

// File: rtl/pteg_pkg.sv
package pteg_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned SEG_COUNT  = 16;
  localparam int unsigned SEG_SEL_W  = $clog2(SEG_COUNT);
  localparam int unsigned VSID_W     = 24;
  localparam int unsigned HASH_W     = 19;
  localparam int unsigned PAGE_IDX_W = 16;
  localparam int unsigned MASK_W     = 9;
  localparam int unsigned HASH_LO_W  = HASH_W - MASK_W;
  localparam int unsigned ORIGIN_W   = 16;
  localparam int unsigned ORIGIN_HI_W = ORIGIN_W - MASK_W;
  localparam int unsigned ALIGN_W    = 6;
  localparam int unsigned API_W      = 6;
  localparam int unsigned PAGE_SHIFT = 12;

  typedef struct packed {
    logic capture;
  } ctrlStrobes_t;
endpackage

// File: rtl/pteg_hash_unit.sv
module pteg_hash_unit
  import pteg_pkg::*;
(
  input  logic [HASH_W-1:0]     vsidLow,
  input  logic [PAGE_IDX_W-1:0] pageIdx,
  input  logic                  hashSel,
  output logic [HASH_W-1:0]     hashOut
);
  localparam int unsigned PAD_W = HASH_W - PAGE_IDX_W;

  logic [HASH_W-1:0] primaryHash;

  always_comb begin
    primaryHash = vsidLow ^ {{PAD_W{1'b0}}, pageIdx};
    hashOut     = hashSel ? ~primaryHash : primaryHash;
  end
endmodule

// File: rtl/pteg_ctrl.sv
module pteg_ctrl
  import pteg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         outReady,
  output logic         inReady,
  output logic         outValid,
  output ctrlStrobes_t strobes
);
  logic outValidQ;

  always_comb begin
    inReady         = !outValidQ || outReady;
    strobes.capture = inValid && inReady;
    outValid        = outValidQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValidQ <= 1'b0;
    end else if (strobes.capture) begin
      outValidQ <= 1'b1;
    end else if (outReady) begin
      outValidQ <= 1'b0;
    end
  end

  p_accept_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  p_stall_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  p_stall_keeps_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);
endmodule

// File: rtl/pteg_datapath.sv
module pteg_datapath
  import pteg_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobes_t                strobes,
  input  logic                        outValid,
  input  logic                        outReady,
  input  logic [ADDR_W-1:0]           effAddr,
  input  logic [SEG_COUNT*ADDR_W-1:0] segFile,
  input  logic [ADDR_W-1:0]           tableCfg,
  input  logic                        hashSel,
  output logic [ADDR_W-1:0]           groupAddr,
  output logic [ADDR_W-1:0]           cmpWord
);
  logic [ADDR_W-1:0]    segArr [SEG_COUNT];
  logic [SEG_SEL_W-1:0] segIdx;
  logic [ADDR_W-1:0]    selSeg;
  logic [VSID_W-1:0]    vsid;
  logic [HASH_W-1:0]    hashVal;
  logic [ORIGIN_W-1:0]  origin;
  logic [MASK_W-1:0]    hashMask;
  logic [MASK_W-1:0]    mergedMid;
  logic [ADDR_W-1:0]    nextAddr;
  logic [ADDR_W-1:0]    nextCmp;
  logic [ADDR_W-1:0]    groupAddrQ;
  logic [ADDR_W-1:0]    cmpWordQ;

  for (genvar i = 0; i < SEG_COUNT; i++) begin : g_seg_unpack
    assign segArr[i] = segFile[i*ADDR_W +: ADDR_W];
  end

  always_comb begin
    segIdx = effAddr[ADDR_W-1 -: SEG_SEL_W];
    selSeg = segArr[segIdx];
    vsid   = selSeg[VSID_W-1:0];
  end

  pteg_hash_unit u_hash (
    .vsidLow (vsid[HASH_W-1:0]),
    .pageIdx (effAddr[PAGE_SHIFT +: PAGE_IDX_W]),
    .hashSel (hashSel),
    .hashOut (hashVal)
  );

  always_comb begin
    origin    = tableCfg[ADDR_W-1 -: ORIGIN_W];
    hashMask  = tableCfg[MASK_W-1:0];
    mergedMid = origin[MASK_W-1:0] | (hashMask & hashVal[HASH_W-1 -: MASK_W]);
    nextAddr  = {origin[ORIGIN_W-1 -: ORIGIN_HI_W], mergedMid,
                 hashVal[HASH_LO_W-1:0], {ALIGN_W{1'b0}}};
    nextCmp   = {1'b1, vsid, hashSel,
                 effAddr[ADDR_W-SEG_SEL_W-1 -: API_W]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      groupAddrQ <= '0;
      cmpWordQ   <= '0;
    end else if (strobes.capture) begin
      groupAddrQ <= nextAddr;
      cmpWordQ   <= nextCmp;
    end
  end

  assign groupAddr = groupAddrQ;
  assign cmpWord   = cmpWordQ;

  p_hold_data_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> ($stable(groupAddr) && $stable(cmpWord)));

  p_origin_top_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (groupAddr[31:25] == $past(tableCfg[31:25])));

  p_hash_select_bit_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (cmpWord[6] == $past(hashSel) && cmpWord[31]));

  p_page_index_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (cmpWord[5:0] == $past(effAddr[27:22])));
endmodule

// File: rtl/pteg_addr_gen.sv
module pteg_addr_gen
  import pteg_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  output logic                        inReady,
  input  logic [ADDR_W-1:0]           effAddr,
  input  logic [SEG_COUNT*ADDR_W-1:0] segFile,
  input  logic [ADDR_W-1:0]           tableCfg,
  input  logic                        hashSel,
  output logic                        outValid,
  input  logic                        outReady,
  output logic [ADDR_W-1:0]           groupAddr,
  output logic [ADDR_W-1:0]           cmpWord
);
  ctrlStrobes_t strobes;

  pteg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobes  (strobes)
  );

  pteg_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .outValid  (outValid),
    .outReady  (outReady),
    .effAddr   (effAddr),
    .segFile   (segFile),
    .tableCfg  (tableCfg),
    .hashSel   (hashSel),
    .groupAddr (groupAddr),
    .cmpWord   (cmpWord)
  );
endmodule

// File: tb/test_pteg_addr_gen.sv
module test_pteg_addr_gen;
  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic         inReady;
  logic [31:0]  effAddr;
  logic [511:0] segFile;
  logic [31:0]  tableCfg;
  logic         hashSel;
  logic         outValid;
  logic         outReady;
  logic [31:0]  groupAddr;
  logic [31:0]  cmpWord;

  int nChecks = 0;
  int nFail   = 0;
  logic [31:0] expAddrQ[$];
  logic [31:0] expCmpQ[$];
  string       tagQ[$];
  logic        lastAccepted;

  always #4 clk = ~clk;

  pteg_addr_gen i_pteg_addr_gen (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .effAddr(effAddr), .segFile(segFile), .tableCfg(tableCfg),
    .hashSel(hashSel), .outValid(outValid), .outReady(outReady),
    .groupAddr(groupAddr), .cmpWord(cmpWord)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] segVsid(logic [31:0] ea);
    int idx = int'(ea >> 28);
    return (segFile >> (idx * 32)) & 32'h00FF_FFFF;
  endfunction

  function automatic logic [31:0] refHash(logic [31:0] ea, logic sel);
    logic [31:0] h;
    h = (segVsid(ea) & 32'h7FFFF) ^ ((ea >> 12) & 32'hFFFF);
    if (sel) h = ~h & 32'h7FFFF;
    return h;
  endfunction

  function automatic logic [31:0] refAddr(logic [31:0] ea, logic sel, logic [31:0] cfg);
    logic [31:0] h = refHash(ea, sel);
    logic [31:0] mid;
    mid = ((cfg >> 16) & 32'h1FF) | (cfg & 32'h1FF & (h >> 10));
    return (cfg & 32'hFE00_0000) | (mid << 16) | ((h & 32'h3FF) << 6);
  endfunction

  function automatic logic [31:0] refCmp(logic [31:0] ea, logic sel);
    return 32'h8000_0000 | (segVsid(ea) << 7) | (32'(sel) << 6) | ((ea >> 22) & 32'h3F);
  endfunction

  task automatic cycle();
    logic popNow, pushNow, heldNow;
    logic [31:0] prevAddr, prevCmp;
    #1;
    popNow   = outValid && outReady;
    pushNow  = inValid && inReady;
    heldNow  = outValid && !outReady;
    prevAddr = groupAddr;
    prevCmp  = cmpWord;
    if (heldNow) check("R9 inReady under stall", 32'(inReady), 32'd0);
    if (pushNow) begin
      expAddrQ.push_back(refAddr(effAddr, hashSel, tableCfg));
      expCmpQ.push_back(refCmp(effAddr, hashSel));
    end
    lastAccepted = pushNow;
    @(negedge clk);
    if (popNow) begin
      void'(expAddrQ.pop_front());
      void'(expCmpQ.pop_front());
      void'(tagQ.pop_front());
    end
    check("R8 outValid", 32'(outValid), 32'(expAddrQ.size() > 0));
    if (heldNow) begin
      check("R9 held addr", groupAddr, prevAddr);
      check("R9 held cmp", cmpWord, prevCmp);
    end
    if (outValid && expAddrQ.size() > 0 && !heldNow) begin
      check({tagQ[0], " addr"}, groupAddr, expAddrQ[0]);
      check("R4 addr[31:25]", 32'(groupAddr[31:25]), 32'(expAddrQ[0][31:25]));
      check("R5 addr[24:16]", 32'(groupAddr[24:16]), 32'(expAddrQ[0][24:16]));
      check("R6 addr[15:0]", 32'(groupAddr[15:0]), 32'(expAddrQ[0][15:0]));
      check("R7 cmpWord", cmpWord, expCmpQ[0]);
    end
  endtask

  task automatic send(logic [31:0] ea, logic sel, logic [31:0] cfg, string tag, logic rdy);
    inValid  = 1'b1;
    effAddr  = ea;
    hashSel  = sel;
    tableCfg = cfg;
    outReady = rdy;
    tagQ.push_back(tag);
    do begin
      cycle();
      outReady = ($urandom % 2) == 0 ? rdy : 1'b1;
    end while (!lastAccepted);
    inValid = 1'b0;
  endtask

  function automatic logic [31:0] mkCfg(logic [15:0] org, logic [6:0] resv, int ones);
    logic [8:0] m = 9'((32'd1 << ones) - 1);
    return {org, resv, m};
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL R8 watchdog got=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; outReady = 1'b1; hashSel = 1'b0;
    effAddr = '0; tableCfg = '0;
    for (int i = 0; i < 16; i++)
      segFile[i*32 +: 32] = {$urandom} ^ (32'h0011_1111 * 32'(i + 1));
    repeat (4) @(negedge clk);
    check("R10 outValid in reset", 32'(outValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 outValid after reset", 32'(outValid), 32'd0);
    check("R10 inReady after reset", 32'(inReady), 32'd1);

    for (int i = 0; i < 16; i++)
      send({4'(i), 28'($urandom)}, 1'b0, mkCfg(16'($urandom), 7'd0, 9), "R1", 1'b1);
    for (int i = 0; i < 40; i++)
      send($urandom, 1'b0, mkCfg(16'($urandom), 7'd0, i % 10), "R2", 1'b1);
    for (int i = 0; i < 40; i++)
      send($urandom, 1'b1, mkCfg(16'($urandom), 7'd0, i % 10), "R3", 1'b1);
    for (int i = 0; i < 20; i++)
      send($urandom, 1'($urandom), mkCfg(16'($urandom), 7'($urandom) | 7'd1, i % 10), "R11", 1'b1);
    for (int i = 0; i < 40; i++)
      send($urandom, 1'($urandom), mkCfg(16'($urandom), 7'd0, i % 10), "R9", 1'($urandom));
    outReady = 1'b1;
    repeat (4) cycle();
    summary();
    $finish;
  end
endmodule